// File: doc/BRIEF.md
# DMA Cycle-Steal Request Handshake Controller

This block runs the peripheral-facing half of one DMA channel working in cycle-steal mode. A peripheral raises a request line. The controller arbitrates for the system bus with a request/grant pair and then sequences a device bus cycle through address, data and end phases. Throughout the address and data phases it drives an acknowledge back to the peripheral.

The data phase ends in the clock where the cycle-end input is high. Every earlier data clock is a wait state. That final data clock is also the decision point for keeping the bus. The peripheral can ask for another transfer without the bus being released: it drops its request once acknowledge appears and raises it again no later than that decision point. A request that arrives later is still kept. The controller then releases the bus, arbitrates again and serves the request.

A mode input chooses how the request is sampled. Direct sampling uses the request pin as it is. Synchronized sampling first passes it through a flop chain, which moves the effective deadline earlier by the chain length.

Top module: `cs_handshake`

## Requirements
- R1: Reset, asynchronous and active low, leaves bus request and acknowledge low, the phase at 0 and no pending request. After reset, no bus request appears unless the request input makes a fresh low-to-high transition.
- R2: A new request (low then high at the sampled input) raises bus request. Bus request stays high with the phase at 0 while grant is low. The address phase follows the first clock edge that samples grant high.
- R3: Acknowledge is high during the address phase (phase 1) and the data phase (phase 2). It is low in the end phase (phase 3), including between back-to-back transfers.
- R4: The address phase lasts one clock. The data phase repeats while the cycle-end input is low, one wait state per clock. The sample point is the data clock in which cycle-end is high, so wait states move it later.
- R5: If a new request is seen at or before the sample point, bus request stays high through the end phase and another address phase follows directly.
- R6: Without such a request, bus request drops in the end phase, the clock after the sample point, and the phase returns to 0.
- R7: A new request that appears after the sample point is latched. After release, the controller arbitrates again and runs another transfer.
- R8: A request held high with no low interval is not a new request and starts no further transfer.
- R9: With the mode input low, the request passes through SYNC_STAGES flops. A request first driven in the sample-point clock misses that cycle. One driven one clock earlier meets it.
- R10: With the mode input high, the request is used without delay. A request first driven in the sample-point clock qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_req_i | input | 1 | Transfer request from the peripheral |
| direct_mode_i | input | 1 | 1: use the request directly, 0: through the synchronizer |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| cyc_end_i | input | 1 | Cycle-end acknowledge for the device access |
| bus_req_o | output | 1 | Bus request to the arbiter |
| per_ack_o | output | 1 | Acknowledge to the peripheral during the device cycle |
| phase_o | output | 2 | 0 idle/arbitration, 1 address, 2 data, 3 end |

## Verification
The bench builds the controller with the default SYNC_STAGES of 1. This makes the one-clock deadline shift between the two sampling modes directly observable: the same reassertion clock gives opposite keep/release outcomes. The bench runs data phases with zero to three wait states, which places the sample point at several distances from the start of the data phase. The grant is also held back for several clocks, which exposes the hold behaviour of bus request.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_END  = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_DATA,
    ST_END
  } state_t;

  // A request counts as new only on a low-to-high change of the sampled level.
  function automatic logic is_new_req(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // The bus is kept when a new request is pending or arrives at the sample point.
  function automatic logic keep_bus(input logic pending, input logic fresh);
    return pending | fresh;
  endfunction

  function automatic phase_t phase_of(input state_t st);
    case (st)
      ST_ADDR: return PH_ADDR;
      ST_DATA: return PH_DATA;
      ST_END:  return PH_END;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cs_sampler.sv
module cs_sampler #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic direct_i,
  output logic rise_o
);
  import cs_pkg::*;

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   req_used;
  logic                   prev_q;
  logic                   armed_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= req_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign req_used = direct_i ? req_i : chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= req_used;
      armed_q <= 1'b1;
    end
  end

  assign rise_o = is_new_req(req_used, prev_q);

  // R9
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (chain_q[0] == $past(req_i)));

endmodule

// File: rtl/cs_pending.sv
module cs_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic consume_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= rise_i | (pend_q & ~consume_i);
  end

  assign pend_o = pend_q;

  // R7
  latch_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> pend_q);

endmodule

// File: rtl/cs_seq.sv
module cs_seq (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_grant_i,
  input  logic           cyc_end_i,
  input  logic           pend_i,
  input  logic           rise_i,
  output logic           consume_o,
  output logic           bus_req_o,
  output logic           per_ack_o,
  output cs_pkg::phase_t phase_o
);
  import cs_pkg::*;

  state_t state_q, state_d;
  logic   keep_q, keep_d;
  logic   sample_pt;
  logic   arb_wait;

  assign sample_pt = (state_q == ST_DATA) && cyc_end_i;
  assign arb_wait  = (state_q == ST_ARB) && !bus_grant_i;

  always_comb begin
    state_d = state_q;
    keep_d  = keep_q;
    case (state_q)
      ST_IDLE: if (pend_i || rise_i) state_d = ST_ARB;
      ST_ARB:  if (bus_grant_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (cyc_end_i) begin
          state_d = ST_END;
          keep_d  = keep_bus(pend_i, rise_i);
        end
      end
      ST_END:  state_d = keep_q ? ST_ADDR : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      keep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      keep_q  <= keep_d;
    end
  end

  assign consume_o = ((state_q == ST_ARB) && bus_grant_i) ||
                     ((state_q == ST_END) && keep_q);
  assign bus_req_o = (state_q != ST_IDLE) && !((state_q == ST_END) && !keep_q);
  assign per_ack_o = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign phase_o   = phase_of(state_q);

  // R2
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_wait |=> (bus_req_o && !per_ack_o));
  // R3
  ack_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_pt |=> !per_ack_o);
  // R3
  ack_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |-> bus_req_o);
  // R5
  keep_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_pt && (pend_i || rise_i)) |=> bus_req_o);
  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_pt && !pend_i && !rise_i) |=> !bus_req_o);
  // R8
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && !pend_i && !rise_i) |=> !bus_req_o);

endmodule

// File: rtl/cs_handshake.sv
module cs_handshake #(
  parameter int SYNC_STAGES = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       per_req_i,
  input  logic       direct_mode_i,
  input  logic       bus_grant_i,
  input  logic       cyc_end_i,
  output logic       bus_req_o,
  output logic       per_ack_o,
  output logic [1:0] phase_o
);
  import cs_pkg::*;

  logic   rise;
  logic   pend;
  logic   consume;
  phase_t phase;

  cs_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (per_req_i),
    .direct_i (direct_mode_i),
    .rise_o   (rise)
  );

  cs_pending pending_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .consume_i (consume),
    .pend_o    (pend)
  );

  cs_seq seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_grant_i (bus_grant_i),
    .cyc_end_i   (cyc_end_i),
    .pend_i      (pend),
    .rise_i      (rise),
    .consume_o   (consume),
    .bus_req_o   (bus_req_o),
    .per_ack_o   (per_ack_o),
    .phase_o     (phase)
  );

  assign phase_o = phase;

endmodule

// File: tb/cs_handshake_tb_top.sv
`timescale 1ns/1ps
module cs_handshake_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dreq = 1'b0;
  logic       direct = 1'b0;
  logic       grant = 1'b0;
  logic       xack = 1'b0;
  logic       grant_en = 1'b1;
  logic       bus_req;
  logic       dack;
  logic [1:0] phase;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  cs_handshake dut_i (
    .clk_i(clk), .rst_ni(rst_n), .per_req_i(dreq), .direct_mode_i(direct),
    .bus_grant_i(grant), .cyc_end_i(xack), .bus_req_o(bus_req),
    .per_ack_o(dack), .phase_o(phase)
  );

  initial forever begin
    @(negedge clk);
    grant = grant_en & bus_req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input int p, input int lim, output bit ok);
    ok = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (phase == p) begin ok = 1; break; end
    end
  endtask

  task automatic start_req(input bit hold);
    bit ok;
    @(negedge clk);
    dreq = 1'b1;
    wait_phase(1, 12, ok);
    chk(ok, "R2 address phase reached", int'(phase), 1);
    chk(dack == 1'b1, "R3 ack in address phase", int'(dack), 1);
    if (!hold) dreq = 1'b0;
  endtask

  // One device cycle with ws wait states; request driven high in data clock req_at.
  task automatic service(input int ws, input int req_at);
    bit ok;
    wait_phase(2, 4, ok);
    chk(ok, "R4 data phase reached", int'(phase), 2);
    for (int i = 0; i <= ws; i++) begin
      if (i > 0) @(negedge clk);
      chk(phase == 2'd2, "R4 data phase held through wait states", int'(phase), 2);
      xack = (i == ws);
      if (i == req_at) dreq = 1'b1;
    end
    @(negedge clk);
    xack = 1'b0;
    chk(phase == 2'd3, "R4 end phase after sample point", int'(phase), 3);
    chk(dack == 1'b0, "R3 ack low in end phase", int'(dack), 0);
  endtask

  task automatic after_end(input bit keep, input string tag);
    chk(bus_req == keep, {tag, " bus request in end phase"}, int'(bus_req), int'(keep));
    @(negedge clk);
    chk(phase == (keep ? 2'd1 : 2'd0), {tag, " phase after end"}, int'(phase), keep ? 1 : 0);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(bus_req == 1'b0 && phase == 2'd0, tag, int'(bus_req), 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(bus_req == 1'b0, "R1 bus request in reset", int'(bus_req), 0);
    chk(dack == 1'b0, "R1 ack in reset", int'(dack), 0);
    chk(phase == 2'd0, "R1 phase in reset", int'(phase), 0);
    @(negedge clk); rst_n = 1'b1;
    quiet(4, "R1 idle after reset");
  endtask

  task automatic t_grant_hold;
    direct = 1'b0; grant_en = 1'b0;
    @(negedge clk); dreq = 1'b1;
    repeat (6) @(negedge clk);
    chk(bus_req == 1'b1, "R2 request held without grant", int'(bus_req), 1);
    chk(phase == 2'd0, "R2 phase while waiting", int'(phase), 0);
    chk(dack == 1'b0, "R2 no ack before grant", int'(dack), 0);
    grant_en = 1'b1;
    begin
      bit ok;
      wait_phase(1, 4, ok);
      chk(ok, "R2 address after grant", int'(phase), 1);
    end
    dreq = 1'b0;
    service(0, -1);
    after_end(1'b0, "R6");
    quiet(4, "R6 stays released");
  endtask

  task automatic t_direct_b2b;
    direct = 1'b1;
    start_req(1'b0);
    service(0, 0);
    after_end(1'b1, "R5 R10 same-clock request");
    chk(dack == 1'b1, "R3 ack in second transfer", int'(dack), 1);
    dreq = 1'b0;
    service(0, -1);
    after_end(1'b0, "R6");
  endtask

  task automatic t_sync_late;
    bit ok;
    direct = 1'b0;
    start_req(1'b0);
    service(1, 1);
    after_end(1'b0, "R9 synchronized same-clock misses");
    wait_phase(1, 10, ok);
    chk(ok, "R7 re-arbitration after late request", int'(phase), 1);
    dreq = 1'b0;
    service(0, -1);
    after_end(1'b0, "R6");
  endtask

  task automatic t_sync_early;
    direct = 1'b0;
    start_req(1'b0);
    service(1, 0);
    after_end(1'b1, "R9 synchronized one clock early");
    dreq = 1'b0;
    service(0, -1);
    after_end(1'b0, "R6");
  endtask

  task automatic t_wait_states;
    direct = 1'b1;
    start_req(1'b0);
    service(3, 3);
    after_end(1'b1, "R4 R10 sample point after three waits");
    dreq = 1'b0;
    service(2, -1);
    after_end(1'b0, "R4 release after two waits");
    direct = 1'b0;
    start_req(1'b0);
    service(3, 2);
    after_end(1'b1, "R4 R9 synchronized late sample point");
    dreq = 1'b0;
    service(0, -1);
    after_end(1'b0, "R6");
  endtask

  task automatic t_after_sample;
    bit ok;
    direct = 1'b1;
    start_req(1'b0);
    service(0, -1);
    chk(bus_req == 1'b0, "R6 release before late request", int'(bus_req), 0);
    dreq = 1'b1;
    @(negedge clk);
    chk(phase == 2'd0, "R7 bus given up first", int'(phase), 0);
    wait_phase(1, 10, ok);
    chk(ok, "R7 late request served", int'(phase), 1);
    dreq = 1'b0;
    service(0, -1);
    after_end(1'b0, "R6");
  endtask

  task automatic t_held;
    direct = 1'b0;
    start_req(1'b1);
    service(0, -1);
    after_end(1'b0, "R8 held request");
    quiet(8, "R8 no transfer from held request");
    dreq = 1'b0;
    quiet(3, "R8 idle after drop");
  endtask

  task automatic t_reset_mid;
    direct = 1'b1;
    start_req(1'b0);
    @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; dreq = 1'b0; xack = 1'b0;
    #1;
    chk(bus_req == 1'b0 && dack == 1'b0, "R1 outputs cleared by reset", int'(bus_req), 0);
    chk(phase == 2'd0, "R1 phase cleared by reset", int'(phase), 0);
    @(negedge clk); rst_n = 1'b1;
    quiet(6, "R1 pending request dropped by reset");
  endtask

  initial begin
    t_reset;
    t_grant_hold;
    t_direct_b2b;
    t_sync_late;
    t_sync_early;
    t_wait_states;
    t_after_sample;
    t_held;
    t_reset_mid;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule